// File: doc/BRIEF.md
# Branch and Condition-Code Control Unit

This unit sits in the execute stage of a 16-bit processor. It keeps the four condition flags (negative, zero, overflow, carry) in a register and handles two instruction groups. For conditional branches, it decides whether the branch is taken from the current flags. It also forms the target address from the already-incremented program counter and an 8-bit signed word offset. For condition-code instructions, it sets or clears any chosen subset of the flags. An ALU writes the flags through a separate update port.

The branch decision and the target are combinational. They are valid in the same cycle the instruction word is presented, and they use the flags held in the register at that moment. A flag change takes effect at the next rising clock edge. Decode sorts each word into one of three instruction classes (other, branch, flag operation) in a `unique case`. The unit has no sequencing state beyond the flag register.

Top module: `bcc_unit`

## Requirements
- R1: `br_target` always equals `pc_inc` plus the sign-extended `instr[7:0]` multiplied by two, modulo 2^16. This gives a reach of -128 to +127 words.
- R2: A word is a branch only when `instr[14:11]` is zero and the 4-bit code {`instr[15]`, `instr[10:8]`} is not zero. `br_taken` is 1 only for a valid branch whose condition holds.
- R3: With `instr[15]` = 0, codes 1 to 7 of `instr[10:8]` test, in order: always; Z=0; Z=1; (N^V)=0; (N^V)=1; (Z|(N^V))=0; (Z|(N^V))=1.
- R4: With `instr[15]` = 1, codes 0 to 7 of `instr[10:8]` test, in order: N=0; N=1; C=0 and Z=0; (C|Z)=1; V=0; V=1; C=0; C=1.
- R5: Code 0000 is never taken. This includes the byte-swap pattern with `instr[15:6]` = 0000000011.
- R6: After reset the flags read 0. `flags` is ordered [3]=N, [2]=Z, [1]=V, [0]=C.
- R7: A valid word with `instr[15:5]` = 00000000101 is a flag operation. If `instr[4]` = 1, the flags selected by mask `instr[3:0]` (same order as R6) are set. If `instr[4]` = 0, they are cleared. Unselected flags keep their value. The change is visible after the next clock edge.
- R8: A flag operation with an empty mask (words 0x00A0 and 0x00B0) leaves every flag unchanged.
- R9: While `alu_flag_we` is 1, all four flags load from `alu_flags` at the clock edge. This takes priority over a flag operation in the same cycle.
- R10: Without an ALU update, the flags hold across branches, other instructions, and cycles with `instr_valid` low.
- R11: `br_taken` is 0 whenever `instr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Program counter already advanced past this word |
| alu_flag_we | input | 1 | ALU flag write enable |
| alu_flags | input | 4 | Flags from the ALU, N Z V C |
| br_taken | output | 1 | Branch condition met for a valid branch |
| br_target | output | 16 | Branch destination address |
| flags | output | 4 | Current flags, N Z V C |

## Verification
The bench targets the sign boundaries of the offset: -128 words, +127 words, and wraparound past both ends of the address space. A design that drops the shift or the sign extension lands on the wrong word. Every condition code is run with one flag set that passes and one that fails. A swapped pair of codes, or a missing exclusive-OR in the signed tests, shows up as a wrong `br_taken`. Code 0000, the byte-swap pattern and words with `instr[14:11]` nonzero check that a decoder which is too loose does not report a taken branch. Empty masks, invalid cycles, near-miss flag-operation words and a same-cycle ALU write check that no stray flag write or wrong priority goes unseen.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_FLAGOP = 2'd2
    } instr_class_e;

    typedef enum logic [3:0] {
        BC_NONE   = 4'h0,
        BC_ALWAYS = 4'h1,
        BC_NE     = 4'h2,
        BC_EQ     = 4'h3,
        BC_GE     = 4'h4,
        BC_LT     = 4'h5,
        BC_GT     = 4'h6,
        BC_LE     = 4'h7,
        BC_PL     = 4'h8,
        BC_MI     = 4'h9,
        BC_HI     = 4'hA,
        BC_LOS    = 4'hB,
        BC_VC     = 4'hC,
        BC_VS     = 4'hD,
        BC_CC     = 4'hE,
        BC_CS     = 4'hF
    } br_code_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam logic [10:0] FLAGOP_PREFIX = 11'b000_0000_0101;

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
    import bcc_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int OFF_W   = 8
) (
    input  logic [INSTR_W-1:0] instr,
    output instr_class_e       cls,
    output br_code_e           code,
    output logic [OFF_W-1:0]   offset,
    output logic               op_sense,
    output logic [3:0]         op_mask
);

    logic       group_zero;
    logic       prefix_hit;
    logic [1:0] sel;

    always_comb begin
        code       = br_code_e'({instr[15], instr[10:8]});
        offset     = instr[OFF_W-1:0];
        op_sense   = instr[4];
        op_mask    = instr[3:0];
        group_zero = (instr[14:11] == 4'b0000);
        prefix_hit = (instr[15:5] == FLAGOP_PREFIX);
        sel        = {prefix_hit, group_zero && (code != BC_NONE)};
        unique case (sel)
            2'b01:   cls = CLS_BRANCH;
            2'b10:   cls = CLS_FLAGOP;
            default: cls = CLS_OTHER;
        endcase
    end

endmodule

// File: rtl/bcc_cond_eval.sv
module bcc_cond_eval
    import bcc_pkg::*;
(
    input  flags_t   f,
    input  br_code_e code,
    output logic     cond_true
);

    logic sgn_lt;

    always_comb begin
        sgn_lt = f.n ^ f.v;
        unique case (code)
            BC_NONE:   cond_true = 1'b0;
            BC_ALWAYS: cond_true = 1'b1;
            BC_NE:     cond_true = !f.z;
            BC_EQ:     cond_true = f.z;
            BC_GE:     cond_true = !sgn_lt;
            BC_LT:     cond_true = sgn_lt;
            BC_GT:     cond_true = !(f.z || sgn_lt);
            BC_LE:     cond_true = f.z || sgn_lt;
            BC_PL:     cond_true = !f.n;
            BC_MI:     cond_true = f.n;
            BC_HI:     cond_true = !f.c && !f.z;
            BC_LOS:    cond_true = f.c || f.z;
            BC_VC:     cond_true = !f.v;
            BC_VS:     cond_true = f.v;
            BC_CC:     cond_true = !f.c;
            BC_CS:     cond_true = f.c;
            default:   cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcc_target.sv
module bcc_target #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] pc_inc,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - OFF_W - 1;

    logic [ADDR_W-1:0] byte_disp;

    always_comb begin
        byte_disp = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
        target    = pc_inc + byte_disp;
    end

endmodule

// File: rtl/bcc_flag_reg.sv
module bcc_flag_reg
    import bcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   alu_we,
    input  flags_t alu_flags,
    input  logic   op_en,
    input  logic   op_sense,
    input  flags_t op_mask,
    output flags_t flags_q
);

    flags_t flags_d;

    always_comb begin
        if (alu_we) begin
            flags_d = alu_flags;
        end else if (op_en) begin
            flags_d = op_sense ? (flags_q | op_mask) : (flags_q & ~op_mask);
        end else begin
            flags_d = flags_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    a_r9_alu_load: assert property (@(posedge clk) disable iff (!rst_n)
        alu_we |=> (flags_q == $past(alu_flags)));

    a_r7_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_sense && !alu_we) |=>
            ((flags_q & $past(op_mask)) == $past(op_mask)));

    a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !op_sense && !alu_we) |=> ((flags_q & $past(op_mask)) == '0));

    a_r7_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !alu_we) |=>
            ((flags_q & ~$past(op_mask)) == ($past(flags_q) & ~$past(op_mask))));

    a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_mask == '0) && !alu_we) |=> $stable(flags_q));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_en && !alu_we) |=> $stable(flags_q));

endmodule

// File: rtl/bcc_unit.sv
module bcc_unit
    import bcc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16,
    parameter int OFF_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  pc_inc,
    input  logic               alu_flag_we,
    input  logic [3:0]         alu_flags,
    output logic               br_taken,
    output logic [ADDR_W-1:0]  br_target,
    output logic [3:0]         flags
);

    instr_class_e     cls;
    br_code_e         code;
    logic [OFF_W-1:0] offset;
    logic             op_sense;
    logic [3:0]       op_mask;
    logic             cond_true;
    logic             op_en;
    flags_t           flags_q;

    bcc_decode #(
        .INSTR_W (INSTR_W),
        .OFF_W   (OFF_W)
    ) u_decode (
        .instr    (instr),
        .cls      (cls),
        .code     (code),
        .offset   (offset),
        .op_sense (op_sense),
        .op_mask  (op_mask)
    );

    bcc_cond_eval u_cond (
        .f         (flags_q),
        .code      (code),
        .cond_true (cond_true)
    );

    bcc_target #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_target (
        .pc_inc (pc_inc),
        .offset (offset),
        .target (br_target)
    );

    bcc_flag_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_we    (alu_flag_we),
        .alu_flags (flags_t'(alu_flags)),
        .op_en     (op_en),
        .op_sense  (op_sense),
        .op_mask   (flags_t'(op_mask)),
        .flags_q   (flags_q)
    );

    always_comb begin
        op_en    = instr_valid && (cls == CLS_FLAGOP);
        br_taken = instr_valid && (cls == CLS_BRANCH) && cond_true;
        flags    = flags_q;
    end

    a_r11_idle_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !br_taken);

    a_r5_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15] == 1'b0 && instr[10:8] == 3'b000) |-> !br_taken);

    a_r2_group_bits: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (instr[14:11] == 4'b0000));

    a_r3_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:8] == 8'h01) |-> br_taken);

endmodule

// File: tb/test_bcc_unit.sv
module test_bcc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_inc = '0;
    logic        alu_flag_we = 1'b0;
    logic [3:0]  alu_flags = '0;
    logic        br_taken;
    logic [15:0] br_target;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcc_unit i_bcc_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .pc_inc      (pc_inc),
        .alu_flag_we (alu_flag_we),
        .alu_flags   (alu_flags),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .flags       (flags)
    );

    // {flags NZVC, instr, pc_inc, expected taken, expected target}
    localparam int NV = 30;
    localparam logic [52:0] VEC [0:NV-1] = '{
        {4'b0000, 16'h0105, 16'h1000, 1'b1, 16'h100A},
        {4'b0000, 16'h02FF, 16'h1000, 1'b1, 16'h0FFE},
        {4'b0100, 16'h0210, 16'h2000, 1'b0, 16'h2020},
        {4'b0100, 16'h0380, 16'h2000, 1'b1, 16'h1F00},
        {4'b1000, 16'h047F, 16'h0100, 1'b0, 16'h01FE},
        {4'b1010, 16'h0401, 16'h0100, 1'b1, 16'h0102},
        {4'b0010, 16'h0502, 16'h0300, 1'b1, 16'h0304},
        {4'b0000, 16'h0502, 16'h0300, 1'b0, 16'h0304},
        {4'b0000, 16'h0603, 16'h0400, 1'b1, 16'h0406},
        {4'b0100, 16'h0603, 16'h0400, 1'b0, 16'h0406},
        {4'b0100, 16'h0700, 16'h0500, 1'b1, 16'h0500},
        {4'b0000, 16'h0700, 16'h0500, 1'b0, 16'h0500},
        {4'b1010, 16'h0700, 16'h0500, 1'b0, 16'h0500},
        {4'b0000, 16'h8004, 16'h0600, 1'b1, 16'h0608},
        {4'b1000, 16'h8004, 16'h0600, 1'b0, 16'h0608},
        {4'b1000, 16'h8104, 16'h0600, 1'b1, 16'h0608},
        {4'b0000, 16'h82FE, 16'h0700, 1'b1, 16'h06FC},
        {4'b0001, 16'h82FE, 16'h0700, 1'b0, 16'h06FC},
        {4'b0100, 16'h83FE, 16'h0700, 1'b1, 16'h06FC},
        {4'b0000, 16'h83FE, 16'h0700, 1'b0, 16'h06FC},
        {4'b0000, 16'h8401, 16'h0800, 1'b1, 16'h0802},
        {4'b0010, 16'h8501, 16'h0800, 1'b1, 16'h0802},
        {4'b0000, 16'h8501, 16'h0800, 1'b0, 16'h0802},
        {4'b0001, 16'h8601, 16'h0900, 1'b0, 16'h0902},
        {4'b0001, 16'h8701, 16'h0900, 1'b1, 16'h0902},
        {4'b1111, 16'h00C5, 16'h0A00, 1'b0, 16'h098A},
        {4'b1111, 16'h0088, 16'h0A00, 1'b0, 16'h0910},
        {4'b0000, 16'h1101, 16'h0B00, 1'b0, 16'h0B02},
        {4'b0000, 16'h017F, 16'hFFF0, 1'b1, 16'h00EE},
        {4'b0000, 16'h0180, 16'h0010, 1'b1, 16'hFF10}
    };

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic load_flags(input logic [3:0] f);
        @(negedge clk);
        alu_flag_we = 1'b1;
        alu_flags   = f;
        @(negedge clk);
        alu_flag_we = 1'b0;
    endtask

    task automatic exec_word(input logic [15:0] w, input logic v);
        @(negedge clk);
        instr       = w;
        instr_valid = v;
        @(negedge clk);
        instr_valid = 1'b0;
        instr       = 16'h0000;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: flags clear after reset
        check("R6 reset flags", {12'h0, flags}, 16'h0000);
        // R6/R3: BEQ not taken with Z clear after reset
        instr = 16'h0301; instr_valid = 1'b1; #2;
        check("R6 reset BEQ taken", {15'h0, br_taken}, 16'h0000);
        // R11: invalid word never taken
        instr = 16'h0101; instr_valid = 1'b0; #2;
        check("R11 invalid BR taken", {15'h0, br_taken}, 16'h0000);
        instr = 16'h0000;

        for (int k = 0; k < NV; k++) begin
            logic [52:0] e;
            string ttag;
            e = VEC[k];
            load_flags(e[52:49]);
            instr  = e[48:33];
            pc_inc = e[32:17];
            instr_valid = 1'b1;
            #2;
            if (e[47:44] != 4'b0000)
                ttag = "R2 taken";
            else if (e[48] == 1'b0 && e[42:40] == 3'b000)
                ttag = "R5 taken";
            else if (e[48])
                ttag = "R4 taken";
            else
                ttag = "R3 taken";
            check($sformatf("%s vec %0d", ttag, k), {15'h0, br_taken}, {15'h0, e[16]});
            check($sformatf("R1 target vec %0d", k), br_target, e[15:0]);
            // R10: a branch or other word leaves the flags unchanged
            @(negedge clk);
            instr_valid = 1'b0;
            check($sformatf("R10 flags after vec %0d", k), {12'h0, flags}, {12'h0, e[52:49]});
        end

        // R7: set Z and C (0x00B5), clear Z (0x00A4), set all, clear N and C
        load_flags(4'b0000);
        exec_word(16'h00B5, 1'b1);
        check("R7 set ZC", {12'h0, flags}, 16'h0005);
        exec_word(16'h00A4, 1'b1);
        check("R7 clear Z", {12'h0, flags}, 16'h0001);
        exec_word(16'h00BF, 1'b1);
        check("R7 set all", {12'h0, flags}, 16'h000F);
        exec_word(16'h00A9, 1'b1);
        check("R7 clear NC", {12'h0, flags}, 16'h0006);
        // R8: empty masks with either sense
        exec_word(16'h00A0, 1'b1);
        check("R8 clear empty", {12'h0, flags}, 16'h0006);
        exec_word(16'h00B0, 1'b1);
        check("R8 set empty", {12'h0, flags}, 16'h0006);
        // R10: flag-op word while invalid, and near-miss word with bit 15 set
        exec_word(16'h00BF, 1'b0);
        check("R10 invalid flag op", {12'h0, flags}, 16'h0006);
        exec_word(16'h80B9, 1'b1);
        check("R10 near-miss word", {12'h0, flags}, 16'h0006);
        // R9: ALU write wins over a same-cycle flag operation
        @(negedge clk);
        alu_flag_we = 1'b1; alu_flags = 4'b1001;
        instr = 16'h00BF; instr_valid = 1'b1;
        @(negedge clk);
        alu_flag_we = 1'b0; instr_valid = 1'b0; instr = 16'h0000;
        check("R9 ALU priority", {12'h0, flags}, 16'h0009);
        // R9/R4: flags loaded by the ALU steer the next branch (BMI)
        instr = 16'h8102; pc_inc = 16'h0C00; instr_valid = 1'b1; #2;
        check("R4 BMI after ALU load", {15'h0, br_taken}, 16'h0001);
        instr_valid = 1'b0; #1;
        check("R11 BMI invalid", {15'h0, br_taken}, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule